// File: doc/BRIEF.md
# Legacy 16-bit ALU with flags

This block is the integer arithmetic and logic unit of a 16-bit segmented-architecture processor. The core presents an operation code, a size select, two operands and the current status word on one cycle, with a valid strobe. On the next clock edge the block presents the result, the updated status word, a result-valid pulse and a write strobe for the destination register.

Each operation class has its own rule for which status bits it touches. Add and subtract style operations update all six arithmetic flags. Increment and decrement leave the carry alone. Logic operations clear carry and overflow. Complement touches nothing. Compare and test update the flags but do not write their destination. Operands are bytes or words, chosen per operation. Every status bit the unit does not own is copied from input to output.

Top module: `legacy_alu16`

## Requirements
- R1: A result appears one clock edge after `op_vld` is sampled high, with `res_vld` high for exactly that one cycle. While `op_vld` is low, `res_out` and `flags_out` hold and `res_vld` and `wr_en` stay low.
- R2: Owned status bits are carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Every other bit of `flags_out`, including trap (8), interrupt enable (9) and direction (10), equals `flags_in`.
- R3: Code 0 adds and code 1 adds plus the incoming carry. Carry is the carry out of the operand's top bit, overflow is the signed overflow, and auxiliary carry is the carry out of bit 3.
- R4: Code 2 subtracts B from A and code 3 also subtracts the incoming carry. Code 4 computes A minus B for the flags only. Carry and auxiliary carry report a borrow from the top bit and from bit 3.
- R5: Code 5 returns zero minus A, with the flags of that subtraction, so carry is set exactly when A is nonzero.
- R6: Code 6 adds one to A and code 7 subtracts one from A. Both update parity, auxiliary carry, zero, sign and overflow, and leave carry at its incoming value.
- R7: Codes 8 (AND), 9 (OR), 10 (XOR) and 11 (TEST, an AND) clear carry and overflow, set zero, sign and parity from the result, and leave auxiliary carry unchanged.
- R8: Code 12 returns the ones' complement of A and `flags_out` equals `flags_in`.
- R9: `wr_en` pulses with `res_vld` for every code except 4 (compare), 11 (test) and 13 to 15.
- R10: With `wide` low, only the low bytes of the operands are used, `res_out[15:8]` is zero, and carry, zero, sign and overflow are taken at byte width. Parity always counts the low 8 result bits and is set for an even count.
- R11: Codes 13 to 15 give a zero result and leave all flags at their incoming values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_vld | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code (see R3 to R11) |
| wide | input | 1 | 1 = word operands, 0 = byte operands |
| opa | input | 16 | Operand A (destination operand) |
| opb | input | 16 | Operand B (source operand) |
| flags_in | input | 16 | Current status word |
| res_out | output | 16 | Registered result |
| flags_out | output | 16 | Registered updated status word |
| res_vld | output | 1 | Result valid, one cycle |
| wr_en | output | 1 | Destination write strobe |

## Verification
Every result, status word and strobe is due one edge after the operation is sampled. No other value has a different latency. Each test task drives its inputs on a falling edge and lets one rising edge capture them. It samples all outputs on the following falling edge, lowers `op_vld` there, and compares them with values computed from integer arithmetic in the bench. For the hold behaviour, a task lets one more rising edge pass with `op_vld` low. It then checks that the strobes have dropped and that the result has not moved.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_TEST = 4'd11,
    OP_NOT  = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOT = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    CL_NONE  = 2'd0,
    CL_ARITH = 2'd1,
    CL_LOGIC = 2'd2,
    CL_PASS  = 2'd3
  } op_class_e;

  // positions of the owned status bits; the neighbouring control logic decodes them
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_OF = 11;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W  = 16,
  parameter int NB = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  input  logic         wide,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         af,
  output logic         of
);
  localparam int HI = W - NB;

  logic [W-1:0]  bx;
  logic          c0;
  logic [W:0]    full;
  logic [NB:0]   low;
  logic          cout;
  logic          sa, sb, sr;

  always_comb begin
    // subtraction runs as a + ~b + ~borrow
    bx   = sub ? ~b : b;
    c0   = cin ^ sub;
    full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, c0};
    low  = {1'b0, a[NB-1:0]} + {1'b0, bx[NB-1:0]} + {{NB{1'b0}}, c0};
    if (wide) begin
      res  = full[W-1:0];
      cout = full[W];
      sa   = a[W-1];
      sb   = bx[W-1];
    end else begin
      res  = {{HI{1'b0}}, low[NB-1:0]};
      cout = low[NB];
      sa   = a[NB-1];
      sb   = bx[NB-1];
    end
    sr = wide ? res[W-1] : res[NB-1];
    cf = cout ^ sub;
    af = a[4] ^ b[4] ^ res[4];
    of = (sa == sb) && (sr != sa);
  end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W  = 16,
  parameter int NB = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  input  logic         wide,
  output logic [W-1:0] res
);
  localparam int HI = W - NB;

  logic [W-1:0] raw;

  always_comb begin
    unique case (fn)
      LF_AND:  raw = a & b;
      LF_OR:   raw = a | b;
      LF_XOR:  raw = a ^ b;
      default: raw = ~a;
    endcase
    res = wide ? raw : {{HI{1'b0}}, raw[NB-1:0]};
  end

endmodule

// File: rtl/alu16_status.sv
module alu16_status #(
  parameter int W  = 16,
  parameter int NB = 8
) (
  input  logic [W-1:0] res,
  input  logic         wide,
  output logic         zf,
  output logic         sf,
  output logic         pf
);
  always_comb begin
    zf = wide ? (res == '0) : (res[NB-1:0] == '0);
    sf = wide ? res[W-1] : res[NB-1];
    pf = ~^res[7:0];
  end

endmodule

// File: rtl/legacy_alu16.sv
module legacy_alu16
  import alu16_pkg::*;
#(
  parameter int W  = 16,
  parameter int NB = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_vld,
  input  logic [3:0]   op_sel,
  input  logic         wide,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [15:0]  flags_in,
  output logic [W-1:0] res_out,
  output logic [15:0]  flags_out,
  output logic         res_vld,
  output logic         wr_en
);
  localparam int HI = W - NB;

  // operand steering
  logic [W-1:0] as_a, as_b;
  logic         as_cin, as_sub, keep_cf, nxt_wr;
  op_class_e    cls;
  logic_fn_e    lfn;

  // unit outputs
  logic [W-1:0] as_res, lg_res, sel_res;
  logic         as_cf, as_af, as_of;
  logic         st_zf, st_sf, st_pf;
  logic [15:0]  nxt_flags;

  // registers
  logic [W-1:0] res_q;
  logic [15:0]  flags_q;
  logic         vld_q, wr_q;

  always_comb begin
    as_a    = opa;
    as_b    = opb;
    as_cin  = 1'b0;
    as_sub  = 1'b0;
    keep_cf = 1'b0;
    cls     = CL_NONE;
    lfn     = LF_AND;
    nxt_wr  = 1'b1;
    case (op_sel)
      OP_ADD:  cls = CL_ARITH;
      OP_ADC:  begin cls = CL_ARITH; as_cin = flags_in[FB_CF]; end
      OP_SUB:  begin cls = CL_ARITH; as_sub = 1'b1; end
      OP_SBB:  begin cls = CL_ARITH; as_sub = 1'b1; as_cin = flags_in[FB_CF]; end
      OP_CMP:  begin cls = CL_ARITH; as_sub = 1'b1; nxt_wr = 1'b0; end
      OP_NEG:  begin cls = CL_ARITH; as_sub = 1'b1; as_a = '0; as_b = opa; end
      OP_INC:  begin cls = CL_ARITH; as_b = W'(1); keep_cf = 1'b1; end
      OP_DEC:  begin cls = CL_ARITH; as_b = W'(1); as_sub = 1'b1; keep_cf = 1'b1; end
      OP_AND:  begin cls = CL_LOGIC; lfn = LF_AND; end
      OP_OR:   begin cls = CL_LOGIC; lfn = LF_OR;  end
      OP_XOR:  begin cls = CL_LOGIC; lfn = LF_XOR; end
      OP_TEST: begin cls = CL_LOGIC; lfn = LF_AND; nxt_wr = 1'b0; end
      OP_NOT:  begin cls = CL_PASS;  lfn = LF_NOT; end
      default: nxt_wr = 1'b0;
    endcase
  end

  alu16_addsub #(.W(W), .NB(NB)) u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub), .wide(wide),
    .res(as_res), .cf(as_cf), .af(as_af), .of(as_of)
  );

  alu16_logic #(.W(W), .NB(NB)) u_logic (
    .a(opa), .b(opb), .fn(lfn), .wide(wide), .res(lg_res)
  );

  always_comb begin
    unique case (cls)
      CL_ARITH:          sel_res = as_res;
      CL_LOGIC, CL_PASS: sel_res = lg_res;
      default:           sel_res = '0;
    endcase
  end

  alu16_status #(.W(W), .NB(NB)) u_status (
    .res(sel_res), .wide(wide), .zf(st_zf), .sf(st_sf), .pf(st_pf)
  );

  always_comb begin
    nxt_flags = flags_in;
    if (cls == CL_ARITH) begin
      if (!keep_cf) nxt_flags[FB_CF] = as_cf;
      nxt_flags[FB_AF] = as_af;
      nxt_flags[FB_OF] = as_of;
    end
    if (cls == CL_LOGIC) begin
      nxt_flags[FB_CF] = 1'b0;
      nxt_flags[FB_OF] = 1'b0;
    end
    if (cls == CL_ARITH || cls == CL_LOGIC) begin
      nxt_flags[FB_ZF] = st_zf;
      nxt_flags[FB_SF] = st_sf;
      nxt_flags[FB_PF] = st_pf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      wr_q    <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      vld_q <= op_vld;
      if (op_vld) begin
        wr_q    <= nxt_wr;
        res_q   <= sel_res;
        flags_q <= nxt_flags;
      end
    end
  end

  assign res_out   = res_q;
  assign flags_out = flags_q;
  assign res_vld   = vld_q;
  assign wr_en     = vld_q & wr_q;

  // R1
  wr_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> res_vld);

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_vld) |-> (!res_vld && $stable(res_out) && $stable(flags_out)));

  // R2
  unowned_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (flags_out & 16'hF72A) == ($past(flags_in) & 16'hF72A));

  // R6
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && ($past(op_sel) == OP_INC || $past(op_sel) == OP_DEC))
      |-> flags_out[FB_CF] == $past(flags_in[FB_CF]));

  // R8
  not_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op_sel) == OP_NOT) |-> flags_out == $past(flags_in));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && ($past(op_sel) == OP_CMP || $past(op_sel) == OP_TEST)) |-> !wr_en);

  // R10
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !$past(wide)) |-> res_out[W-1:NB] == '0);

endmodule

// File: tb/sim_legacy_alu16.sv
module sim_legacy_alu16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_vld;
  logic [3:0]  op_sel;
  logic        wide;
  logic [15:0] opa, opb, flags_in;
  logic [15:0] res_out, flags_out;
  logic        res_vld, wr_en;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_alu16 u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_sel(op_sel), .wide(wide),
    .opa(opa), .opb(opb), .flags_in(flags_in),
    .res_out(res_out), .flags_out(flags_out), .res_vld(res_vld), .wr_en(wr_en)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // independent integer model of the requirements
  task automatic model(input [3:0] op, input bit w, input [15:0] a, b, fi,
                       output [15:0] er, output [15:0] ef, output bit ewr);
    int m, hb, ua, ub, x, y, cc, s, ss, sx, sy, r;
    bit sub, arith, lg, kcf;
    m = w ? 65535 : 255;
    hb = w ? 32768 : 128;
    ua = int'(a) & m; ub = int'(b) & m;
    x = ua; y = ub; cc = 0; sub = 0; arith = (op <= 7); lg = (op >= 8 && op <= 11); kcf = 0;
    case (op)
      1: cc = fi[0];
      2, 4: sub = 1;
      3: begin sub = 1; cc = fi[0]; end
      5: begin sub = 1; x = 0; y = ua; end
      6: begin y = 1; kcf = 1; end
      7: begin y = 1; sub = 1; kcf = 1; end
      default: ;
    endcase
    ef = fi;
    r = 0;
    if (arith) begin
      s = sub ? x - y - cc : x + y + cc;
      r = s & m;
      sx = (x & hb) != 0 ? x - (m + 1) : x;
      sy = (y & hb) != 0 ? y - (m + 1) : y;
      ss = sub ? sx - sy - cc : sx + sy + cc;
      if (!kcf) ef[0] = sub ? (s < 0) : (s > m);
      ef[4] = sub ? ((x & 15) - (y & 15) - cc < 0) : ((x & 15) + (y & 15) + cc > 15);
      ef[11] = (ss > hb - 1) || (ss < -hb);
    end else begin
      case (op)
        8, 11: r = ua & ub;
        9: r = ua | ub;
        10: r = ua ^ ub;
        12: r = (~ua) & m;
        default: r = 0;
      endcase
    end
    if (lg) begin ef[0] = 0; ef[11] = 0; end
    if (arith || lg) begin
      ef[6] = (r == 0);
      ef[7] = (r & hb) != 0;
      ef[2] = ($countones(r[7:0]) % 2) == 0;
    end
    er = r[15:0];
    ewr = !(op == 4 || op == 11 || op > 12);
  endtask

  task automatic run(input string req, input [3:0] op, input bit w,
                     input [15:0] a, b, fi);
    logic [15:0] er, ef;
    bit ewr;
    model(op, w, a, b, fi, er, ef, ewr);
    op_sel = op; wide = w; opa = a; opb = b; flags_in = fi; op_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_vld = 1'b0;
    chk(req, "res_vld", int'(res_vld), 1);
    chk(req, "res_out", int'(res_out), int'(er));
    chk(req, "flags_out", int'(flags_out), int'(ef));
    chk(req, "wr_en", int'(wr_en), int'(ewr));
  endtask

  task automatic t_reset;
    chk("R1", "reset res_vld", int'(res_vld), 0);
    chk("R1", "reset wr_en", int'(wr_en), 0);
    chk("R1", "reset res_out", int'(res_out), 0);
    chk("R1", "reset flags_out", int'(flags_out), 0);
  endtask

  task automatic t_add;
    run("R3", 4'd0, 1, 16'h7FFF, 16'h0001, 16'h0000);
    run("R3", 4'd0, 1, 16'hFFFF, 16'h0001, 16'h0000);
    run("R3", 4'd1, 1, 16'h0F0F, 16'h1010, 16'h0001);
    run("R3", 4'd1, 1, 16'h1234, 16'h4321, 16'h0000);
  endtask

  task automatic t_sub;
    run("R4", 4'd2, 1, 16'h0000, 16'h0001, 16'h0000);
    run("R4", 4'd2, 1, 16'h8000, 16'h0001, 16'h0000);
    run("R4", 4'd3, 1, 16'h0010, 16'h0010, 16'h0001);
    run("R4", 4'd4, 1, 16'h5555, 16'h5555, 16'h0000);
    run("R9", 4'd4, 1, 16'h0001, 16'h0002, 16'h0000);
  endtask

  task automatic t_neg;
    run("R5", 4'd5, 1, 16'h0000, 16'h0000, 16'h0001);
    run("R5", 4'd5, 1, 16'h0001, 16'h0000, 16'h0000);
    run("R5", 4'd5, 1, 16'h8000, 16'h0000, 16'h0000);
  endtask

  task automatic t_incdec;
    run("R6", 4'd6, 1, 16'hFFFF, 16'h0000, 16'h0001);
    run("R6", 4'd6, 1, 16'h7FFF, 16'h0000, 16'h0000);
    run("R6", 4'd7, 1, 16'h0000, 16'h0000, 16'h0000);
    run("R6", 4'd7, 1, 16'h8000, 16'h0000, 16'h0001);
  endtask

  task automatic t_logic;
    run("R7", 4'd8, 1, 16'hF0F0, 16'h0F0F, 16'h0811);
    run("R7", 4'd9, 1, 16'h8000, 16'h0003, 16'h0801);
    run("R7", 4'd10, 1, 16'hAAAA, 16'hAAAA, 16'h0000);
    run("R9", 4'd11, 1, 16'h8001, 16'hFFFF, 16'h0801);
  endtask

  task automatic t_not;
    run("R8", 4'd12, 1, 16'h00FF, 16'h0000, 16'h08D5);
    run("R8", 4'd12, 0, 16'h1234, 16'h0000, 16'h0000);
  endtask

  task automatic t_byte;
    run("R10", 4'd0, 0, 16'h12FF, 16'h3401, 16'h0000);
    run("R10", 4'd0, 0, 16'h007F, 16'h0001, 16'h0000);
    run("R10", 4'd2, 0, 16'hAB00, 16'h0001, 16'h0000);
    run("R10", 4'd10, 0, 16'hFF03, 16'h0001, 16'h0000);
  endtask

  task automatic t_pass;
    run("R2", 4'd0, 1, 16'h0001, 16'h0001, 16'hF72A);
    run("R2", 4'd3, 1, 16'h0100, 16'h0001, 16'hFFFF);
  endtask

  task automatic t_undef;
    for (int k = 13; k < 16; k++)
      run("R11", 4'(k), 1, 16'h1111, 16'h2222, 16'h0AD5);
  endtask

  task automatic t_idle;
    logic [15:0] r0, f0;
    run("R1", 4'd0, 1, 16'h0100, 16'h0200, 16'h0000);
    r0 = res_out; f0 = flags_out;
    opa = 16'hFFFF; opb = 16'hFFFF; op_sel = 4'd5;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "idle res_vld", int'(res_vld), 0);
    chk("R1", "idle wr_en", int'(wr_en), 0);
    chk("R1", "idle res_out", int'(res_out), int'(r0));
    chk("R1", "idle flags_out", int'(flags_out), int'(f0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_vld = 1'b0; op_sel = '0; wide = 1'b1;
    opa = '0; opb = '0; flags_in = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_neg();
    t_incdec();
    t_logic();
    t_not();
    t_byte();
    t_pass();
    t_undef();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule